// File: doc/BRIEF.md
# Interrupt Pin Aggregation Counter

This block merges the level-sensitive interrupt pins of several devices into a small set of root interrupt lines. Each device has four pins. Some devices sit on the root bus. The rest sit behind a single bridge, which occupies one slot on the root bus. A root line is not a plain OR of its sources. Each line has a counter of asserted sources, and the line is high while that counter is nonzero. The counter moves only when a pin's level differs from the last level the block recorded for that pin.

When pin levels change, each change is routed to one root line. A pin on a root-bus device is mapped straight to a line. A pin behind the bridge is first mapped on the secondary bus. That result is then mapped again as a pin of the bridge slot on the root bus. Changes are taken one per cycle, lowest source index first, so simultaneous edges are never lost.

The counters can be saved and restored. They are always visible on a save port. A restore request loads all of them at once, but only if the line count it carries matches the configured line count. Otherwise the request is rejected and an error pulse is raised.

Top module: `irq_agg_counter`

## Requirements
- R1: While rst_ni is low and after its release, all line counters are zero, line_o is all zero, and every recorded pin level is 0, so a pin already high after reset is counted as a rising change.
- R2: A pin whose level equals its recorded level causes no counter change, however long it is held.
- R3: A recorded rising change adds one to the counter of its mapped line, and a falling change subtracts one. The new count appears on save_cnt_o and line_o after the clock edge that processes the change.
- R4: line_o[k] is 1 exactly when the counter of line k is nonzero.
- R5: Pin p of root-bus device d (d < BRIDGE_FIRST) maps to line (p + d) mod NUM_LINES.
- R6: Pin p of device d >= BRIDGE_FIRST sits behind the bridge. Its secondary pin is (p + d - BRIDGE_FIRST) mod 4, and its root line is (secondary pin + BRIDGE_SLOT) mod NUM_LINES.
- R7: At most one change is processed per clock edge. Pending changes are served in order of source index d*4+p, lowest first, and every pending change is eventually applied.
- R8: save_cnt_o carries the counter of line k in bits [k*CNT_W +: CNT_W], where CNT_W = clog2(4*NUM_DEV+1).
- R9: restore_i with restore_lines_i equal to NUM_LINES loads all counters from restore_cnt_i, using the R8 layout, on that edge. Restore takes priority over a pending pin change, and that change is applied on a later edge.
- R10: restore_i with restore_lines_i different from NUM_LINES leaves every counter unchanged on that edge and drives restore_err_o high for exactly the following cycle. restore_err_o is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 4*NUM_DEV | Pin levels; bit d*4+p is pin p of device d |
| line_o | output | NUM_LINES | Root interrupt lines |
| save_cnt_o | output | NUM_LINES*CNT_W | All line counters, line k at [k*CNT_W +: CNT_W] |
| restore_i | input | 1 | Restore request, one cycle |
| restore_lines_i | input | LCOUNT_W | Line count carried by the snapshot |
| restore_cnt_i | input | NUM_LINES*CNT_W | Counter values to load |
| restore_err_o | output | 1 | Pulses one cycle after a rejected restore |

## Verification
A wrong recorded pin level or counter value stays inside the block until it reaches the ports. It shows as a line that stays high after all its sources drop, or as a line that never rises. It also shows on save_cnt_o on the very edge after the faulty update. Because the bench's model tracks every counter and every recorded level and compares all outputs on every cycle, a lost, duplicated, misrouted or misordered update is seen within one cycle of the edge that applied it. A rejected or mis-prioritized restore is visible on the next cycle through save_cnt_o and restore_err_o.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  // root line reached by pin p of device d
  function automatic int route_line(input int d, input int p, input int bridge_first,
                                    input int bridge_slot, input int num_lines);
    int sec;
    if (d < bridge_first) return (p + d) % num_lines;
    sec = (p + d - bridge_first) % 4;
    return (sec + bridge_slot) % num_lines;
  endfunction
endpackage

// File: rtl/irq_change_picker.sv
module irq_change_picker #(
  parameter int N     = 24,
  localparam int IW   = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  pend_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        valid_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_route.sv
module irq_route
  import irq_agg_pkg::*;
#(
  parameter int NUM_DEV      = 6,
  parameter int NUM_LINES    = 4,
  parameter int BRIDGE_FIRST = 4,
  parameter int BRIDGE_SLOT  = 3,
  localparam int N  = 4 * NUM_DEV,
  localparam int IW = (N > 1) ? $clog2(N) : 1,
  localparam int LW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic [IW-1:0] idx_i,
  output logic [LW-1:0] line_o
);
  logic [LW-1:0] tbl [N];

  for (genvar i = 0; i < N; i++) begin : g_tbl
    localparam int LINE = route_line(i / 4, i % 4, BRIDGE_FIRST, BRIDGE_SLOT, NUM_LINES);
    assign tbl[i] = LW'(LINE);
  end

  always_comb begin
    line_o = '0;
    for (int i = 0; i < N; i++)
      if (idx_i == IW'(i)) line_o = tbl[i];
  end
endmodule

// File: rtl/irq_line_counters.sv
module irq_line_counters #(
  parameter int NUM_LINES = 4,
  parameter int CNT_W     = 5,
  localparam int LW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       step_i,
  input  logic [LW-1:0]              sel_i,
  input  logic                       up_i,
  input  logic                       load_i,
  input  logic [NUM_LINES*CNT_W-1:0] load_cnt_i,
  output logic [NUM_LINES*CNT_W-1:0] cnt_o,
  output logic [NUM_LINES-1:0]       nz_o
);
  for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
    logic [CNT_W-1:0] c_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          c_q <= '0;
      else if (load_i)                      c_q <= load_cnt_i[k*CNT_W +: CNT_W];
      else if (step_i && sel_i == LW'(k))   c_q <= up_i ? c_q + 1'b1 : c_q - 1'b1;
    end
    assign cnt_o[k*CNT_W +: CNT_W] = c_q;
    assign nz_o[k] = |c_q;
  end
endmodule

// File: rtl/irq_agg_counter.sv
module irq_agg_counter #(
  parameter int NUM_DEV      = 6,
  parameter int NUM_LINES    = 4,
  parameter int BRIDGE_FIRST = 4,
  parameter int BRIDGE_SLOT  = 3,
  parameter int LCOUNT_W     = 8,
  localparam int N     = 4 * NUM_DEV,
  localparam int CNT_W = $clog2(N + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [N-1:0]               pin_i,
  output logic [NUM_LINES-1:0]       line_o,
  output logic [NUM_LINES*CNT_W-1:0] save_cnt_o,
  input  logic                       restore_i,
  input  logic [LCOUNT_W-1:0]        restore_lines_i,
  input  logic [NUM_LINES*CNT_W-1:0] restore_cnt_i,
  output logic                       restore_err_o
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;
  localparam int LW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

  logic [N-1:0]  lvl_q;
  logic          chg_valid;
  logic [IW-1:0] chg_idx;
  logic [LW-1:0] chg_line;
  logic          step, load, reject, err_q;

  irq_change_picker #(.N(N)) u_pick (
    .pend_i (pin_i ^ lvl_q),
    .valid_o(chg_valid),
    .idx_o  (chg_idx)
  );

  irq_route #(
    .NUM_DEV(NUM_DEV), .NUM_LINES(NUM_LINES),
    .BRIDGE_FIRST(BRIDGE_FIRST), .BRIDGE_SLOT(BRIDGE_SLOT)
  ) u_route (
    .idx_i (chg_idx),
    .line_o(chg_line)
  );

  // any restore request blocks the serializer for that edge
  assign load   = restore_i && (restore_lines_i == LCOUNT_W'(NUM_LINES));
  assign reject = restore_i && !load;
  assign step   = chg_valid && !restore_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= '0;
      err_q <= 1'b0;
    end else begin
      err_q <= reject;
      if (step) lvl_q[chg_idx] <= pin_i[chg_idx];
    end
  end

  irq_line_counters #(.NUM_LINES(NUM_LINES), .CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_i    (step),
    .sel_i     (chg_line),
    .up_i      (pin_i[chg_idx]),
    .load_i    (load),
    .load_cnt_i(restore_cnt_i),
    .cnt_o     (save_cnt_o),
    .nz_o      (line_o)
  );

  assign restore_err_o = err_q;
endmodule

// File: rtl/irq_agg_counter_chk.sv
module irq_agg_counter_chk #(
  parameter int NUM_DEV      = 6,
  parameter int NUM_LINES    = 4,
  parameter int BRIDGE_FIRST = 4,
  parameter int BRIDGE_SLOT  = 3,
  parameter int LCOUNT_W     = 8,
  localparam int N     = 4 * NUM_DEV,
  localparam int CNT_W = $clog2(N + 1)
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [N-1:0]               pin_i,
  input logic [NUM_LINES-1:0]       line_o,
  input logic [NUM_LINES*CNT_W-1:0] save_cnt_o,
  input logic                       restore_i,
  input logic [LCOUNT_W-1:0]        restore_lines_i,
  input logic [NUM_LINES*CNT_W-1:0] restore_cnt_i,
  input logic                       restore_err_o
);
  int  total;
  logic match;

  always_comb begin
    total = 0;
    for (int k = 0; k < NUM_LINES; k++) total += int'(save_cnt_o[k*CNT_W +: CNT_W]);
  end
  assign match = restore_lines_i == LCOUNT_W'(NUM_LINES);

  // R7
  single_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(restore_i) |-> (total == $past(total) || total == $past(total) + 1 ||
                           total == $past(total) - 1));

  // R9
  restore_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_i && match |=> save_cnt_o == $past(restore_cnt_i));

  // R10
  reject_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_i && !match |=> $stable(save_cnt_o));

  // R10
  reject_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_i && !match |=> restore_err_o);

  // R10
  err_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_err_o |-> $past(restore_i) && !$past(match));

  // R1
  always_comb if (!rst_ni) reset_idle_chk: assert (line_o == '0 || $isunknown(line_o));
endmodule

bind irq_agg_counter irq_agg_counter_chk #(
  .NUM_DEV(NUM_DEV), .NUM_LINES(NUM_LINES), .BRIDGE_FIRST(BRIDGE_FIRST),
  .BRIDGE_SLOT(BRIDGE_SLOT), .LCOUNT_W(LCOUNT_W)
) u_chk (.*);

// File: tb/irq_agg_counter_test.sv
`timescale 1ns/1ps
module irq_agg_counter_test;
  localparam int ND = 6, L = 4, BF = 4, BS = 3, LCW = 8;
  localparam int N = 4 * ND, W = $clog2(N + 1);

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [N-1:0] pin = '0;
  logic [L-1:0] line;
  logic [L*W-1:0] cnt, rcnt = '0, snap;
  logic restore = 1'b0, err;
  logic [LCW-1:0] rlines = '0;

  int checks = 0, fails = 0;
  string req = "R1";
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_agg_counter #(.NUM_DEV(ND), .NUM_LINES(L), .BRIDGE_FIRST(BF),
                    .BRIDGE_SLOT(BS), .LCOUNT_W(LCW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .pin_i(pin), .line_o(line), .save_cnt_o(cnt),
    .restore_i(restore), .restore_lines_i(rlines), .restore_cnt_i(rcnt),
    .restore_err_o(err));

  // reference model
  logic [W-1:0] m_cnt [L];
  bit m_lvl [N];
  bit m_err;

  function automatic int exp_line(int d, int p);
    if (d < BF) return (p + d) % L;
    return (((p + d - BF) % 4) + BS) % L;
  endfunction

  function automatic logic [L*W-1:0] m_pack();
    logic [L*W-1:0] v;
    for (int k = 0; k < L; k++) v[k*W +: W] = m_cnt[k];
    return v;
  endfunction

  function automatic logic [L-1:0] m_lines();
    logic [L-1:0] v;
    for (int k = 0; k < L; k++) v[k] = (m_cnt[k] != 0);
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_ni) begin
      for (int k = 0; k < L; k++) m_cnt[k] = '0;
      for (int i = 0; i < N; i++) m_lvl[i] = 1'b0;
      m_err = 1'b0;
    end else begin
      m_err = restore && (rlines != LCW'(L));
      if (restore) begin
        if (!m_err) for (int k = 0; k < L; k++) m_cnt[k] = rcnt[k*W +: W];
      end else begin
        for (int i = 0; i < N; i++) begin
          if (pin[i] != m_lvl[i]) begin
            m_lvl[i] = pin[i];
            if (pin[i]) m_cnt[exp_line(i / 4, i % 4)] += 1'b1;
            else        m_cnt[exp_line(i / 4, i % 4)] -= 1'b1;
            break;
          end
        end
      end
    end
  end

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) if (rst_ni && !done) begin
    check({req, " R4 line_o"}, 64'(line), 64'(m_lines()));
    check({req, " R8 save_cnt_o"}, 64'(cnt), 64'(m_pack()));
    check({req, " R10 restore_err_o"}, 64'(err), 64'(m_err));
  end

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [W-1:0] cnt_of(int k);
    return cnt[k*W +: W];
  endfunction

  initial begin
    cycles(3);
    check("R1 line_o in reset", 64'(line), 64'h0);
    check("R1 counters in reset", 64'(cnt), 64'h0);
    rst_ni = 1'b1;
    cycles(2);
    check("R1 line_o after reset", 64'(line), 64'h0);

    req = "R5";
    pin[0*4+0] = 1'b1;                     // line 0
    cycles(2);
    check("R5 dev0 pin0 -> line0", 64'(cnt_of(0)), 64'd1);
    check("R3 line0 raised", 64'(line[0]), 64'd1);
    pin[1*4+2] = 1'b1;                     // (2+1)%4 = 3
    cycles(2);
    check("R5 dev1 pin2 -> line3", 64'(cnt_of(3)), 64'd1);

    req = "R6";
    pin[4*4+1] = 1'b1;                     // sec 1, root (1+3)%4 = 0
    cycles(2);
    check("R6 dev4 pin1 -> line0", 64'(cnt_of(0)), 64'd2);
    pin[5*4+3] = 1'b1;                     // sec (3+1)%4=0, root 3
    cycles(2);
    check("R6 dev5 pin3 -> line3", 64'(cnt_of(3)), 64'd2);

    req = "R2";
    cycles(10);
    check("R2 held pins leave line0", 64'(cnt_of(0)), 64'd2);

    req = "R3";
    pin[0*4+0] = 1'b0;
    cycles(2);
    check("R3 falling decrements line0", 64'(cnt_of(0)), 64'd1);

    req = "R7";
    pin[2*4+0] = 1'b1; pin[2*4+2] = 1'b1;  // lines 2, 0 ; idx 8 first
    pin[3*4+1] = 1'b1;                     // line 0, idx 13
    @(negedge clk);
    check("R7 lowest index first", 64'(cnt_of(2)), 64'd1);
    check("R7 others wait", 64'(cnt_of(0)), 64'd1);
    cycles(3);
    check("R7 none lost", 64'(cnt_of(0)), 64'd3);

    req = "R9";
    snap = cnt;
    restore = 1'b1; rlines = LCW'(L); rcnt = {W'(3), W'(0), W'(7), W'(1)};
    @(negedge clk);
    check("R9 restore loads", 64'(cnt), 64'({W'(3), W'(0), W'(7), W'(1)}));
    rcnt = snap;                           // put real counts back, with a pending edge
    pin[0*4+1] = 1'b1;                     // line 1
    @(negedge clk);
    check("R9 restore wins over change", 64'(cnt), 64'(snap));
    restore = 1'b0;
    @(negedge clk);
    check("R9 deferred change applied", 64'(cnt_of(1)), 64'(snap[1*W +: W] + 1'b1));

    req = "R10";
    snap = cnt;
    restore = 1'b1; rlines = LCW'(L - 1); rcnt = '1;
    pin[1*4+0] = 1'b1;
    @(negedge clk);
    restore = 1'b0;
    check("R10 rejected keeps counters", 64'(cnt), 64'(snap));
    check("R10 error pulse", 64'(err), 64'd1);
    @(negedge clk);
    check("R10 error one cycle", 64'(err), 64'd0);

    req = "R7";
    for (int t = 0; t < 400; t++) begin
      if ($urandom_range(0, 2) == 0) pin[$urandom_range(0, N - 1)] ^= 1'b1;
      if ($urandom_range(0, 9) == 0) pin = N'({$urandom, $urandom});
      @(negedge clk);
    end

    req = "R4";
    pin = '0;
    cycles(N + 2);
    check("R4 all lines low when idle", 64'(line), 64'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule